// File: doc/BRIEF.md
# Interrupt Enable and Event Flag Register

This block is the single 8-bit interrupt control register of a small microcontroller core. It holds a master enable, an enable for the peripheral group, enables for three local sources and one sticky flag for each of those three sources. The local sources are a one-cycle timer rollover pulse, a rising edge on an external interrupt pin, and a change on any of six port pins. Each port pin is qualified by its own change-enable bit, which comes from a separate 6-bit register outside this block. The peripheral group already has its own flags elsewhere. It arrives here as one request line.

Software reads and writes the register through a plain bus with address, write data, write strobe and combinational read data. The register answers at two addresses, and both reach the same storage. A flag records its event whatever the enables hold. The enables only decide whether a recorded event drives the single interrupt request output to the core. The external pin and the port pins are asynchronous, so each passes through two synchronizer flops before edge or change detection.

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset all eight register bits are 0 and `irq` is 0.
- R2: A write with `bus_we`=1 at address 0x0B or 0x8B loads all eight bits from `bus_wdata`. A read at either address returns the register, with bit 7 = master enable, 6 = peripheral enable, 5 = timer enable, 4 = pin enable, 3 = port enable, 2 = timer flag, 1 = pin flag and 0 = port flag. Any other address reads 0.
- R3: A cycle with `tmr_ovf`=1 sets bit 2 at the next clock edge. The bit then stays set until software writes it to 0.
- R4: A rising edge on `ext_pin` sets bit 1, three clock edges after the input changes (two synchronizer flops, then the flag). A falling edge does not set it.
- R5: A change in either direction on `port_pins[i]` sets bit 0 only while `ioc_en[i]`=1. A change on a pin whose enable bit is 0 is never recorded.
- R6: Writing 0 to a flag clears it. If the flag's event occurs in the same cycle as that write, the flag ends up set.
- R7: `irq` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_req`)). When bit 7 is 0, `irq` is 0 for every source.
- R8: `periph_req` raises `irq` only while both bit 6 and bit 7 are set.
- R9: A write to any address other than 0x0B and 0x8B leaves the register unchanged. The enable bits have no effect on whether a flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, combinational |
| tmr_ovf | input | 1 | Timer rollover pulse, synchronous |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | 6 | Port pins watched for change, asynchronous |
| ioc_en | input | 6 | Per-pin change enable |
| periph_req | input | 1 | Combined peripheral group request |
| irq | output | 1 | Interrupt request to the core |

## Verification
The register bits are the whole state of the block, and every one of them can be read back in the cycle after it changes. A lost flag, a flag set too early, or a write that misses can therefore be seen on `bus_rdata` within one read. A wrong synchronizer or previous-value latch shows up as a flag set at the wrong edge count, or as a change recorded on a masked pin. The bench samples at that exact latency. A fault in the request gating appears on `irq` in the same cycle as the register or `periph_req` changes, so each gating combination is checked right after the write that sets it up.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int unsigned REG_W = 8;

    // Packed MSB first: gie is bit 7, chg_flag is bit 0.
    typedef struct packed {
        logic gie;
        logic pie;
        logic tmr_en;
        logic ext_en;
        logic chg_en;
        logic tmr_flag;
        logic ext_flag;
        logic chg_flag;
    } ictl_reg_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] st1;
        logic [W-1:0] st2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.st1 = async_i;
        s_d.st2 = s_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.st2;

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int unsigned W         = 1,
    parameter bit          RISE_ONLY = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] mask_i,
    output logic         evt_o
);

    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] hit;

    // The previous-value latch follows the pins every cycle, masked or not.
    always_comb begin
        prev_d = cur_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    generate
        if (RISE_ONLY) begin : g_rise
            assign hit = cur_i & ~prev_q & mask_i;
        end else begin : g_any
            assign hit = (cur_i ^ prev_q) & mask_i;
        end
    endgenerate

    assign evt_o = |hit;

endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_ctl_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 8,
    parameter int unsigned          PORT_W   = 6,
    parameter logic [ADDR_W-1:0]    ADDR_PRI = 'h0B,
    parameter logic [ADDR_W-1:0]    ADDR_ALT = 'h8B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tmr_ovf,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_pins,
    input  logic [PORT_W-1:0] ioc_en,
    input  logic              periph_req,
    output logic              irq
);

    ictl_reg_t         r_d, r_q;
    logic              hit;
    logic              ext_sync;
    logic [PORT_W-1:0] port_sync;
    logic              ext_evt;
    logic              chg_evt;

    irq_sync #(.W(1)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_pin), .sync_o(ext_sync)
    );

    irq_sync #(.W(PORT_W)) u_port_sync (
        .clk(clk), .rst_n(rst_n), .async_i(port_pins), .sync_o(port_sync)
    );

    irq_edge_detect #(.W(1), .RISE_ONLY(1'b1)) u_ext_edge (
        .clk(clk), .rst_n(rst_n), .cur_i(ext_sync), .mask_i(1'b1), .evt_o(ext_evt)
    );

    irq_edge_detect #(.W(PORT_W), .RISE_ONLY(1'b0)) u_port_chg (
        .clk(clk), .rst_n(rst_n), .cur_i(port_sync), .mask_i(ioc_en), .evt_o(chg_evt)
    );

    assign hit = (bus_addr == ADDR_PRI) || (bus_addr == ADDR_ALT);

    always_comb begin
        r_d = r_q;
        if (bus_we && hit) r_d = ictl_reg_t'(bus_wdata);
        // An event in the same cycle as a clearing write wins.
        if (tmr_ovf) r_d.tmr_flag = 1'b1;
        if (ext_evt) r_d.ext_flag = 1'b1;
        if (chg_evt) r_d.chg_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = hit ? REG_W'(r_q) : '0;

    assign irq = r_q.gie & ((r_q.tmr_en & r_q.tmr_flag)
                          | (r_q.ext_en & r_q.ext_flag)
                          | (r_q.chg_en & r_q.chg_flag)
                          | (r_q.pie    & periph_req));

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_PRI = 'h0B,
    parameter logic [ADDR_W-1:0] ADDR_ALT = 'h8B
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              tmr_ovf,
    input logic              irq,
    input logic [7:0]        reg_q
);

    logic wr_hit;
    assign wr_hit = bus_we && ((bus_addr == ADDR_PRI) || (bus_addr == ADDR_ALT));

    AST_TMR_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> reg_q[2]); // R3

    AST_TMR_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q[2] && !wr_hit) |=> reg_q[2]); // R3

    AST_WRITE_LOADS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (reg_q[7:3] == $past(bus_wdata[7:3]))); // R2

    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(reg_q[7:3])); // R9

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !bus_wdata[2] && tmr_ovf) |=> reg_q[2]); // R6

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reg_q[7]); // R7

endmodule

bind irq_ctl_reg irq_ctl_chk #(
    .ADDR_W(ADDR_W), .ADDR_PRI(ADDR_PRI), .ADDR_ALT(ADDR_ALT)
) u_irq_ctl_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .tmr_ovf(tmr_ovf), .irq(irq), .reg_q(r_q)
);

// File: tb/irq_ctl_reg_bench.sv
module irq_ctl_reg_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       tmr_ovf = 1'b0;
    logic       ext_pin = 1'b0;
    logic [5:0] port_pins = 6'h00;
    logic [5:0] ioc_en = 6'h00;
    logic       periph_req = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_ctl_reg u_irq_ctl_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
        .port_pins(port_pins), .ioc_en(ioc_en), .periph_req(periph_req), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 reset value", 8'h0B, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_address;
        wr(8'h8B, 8'hF8);
        rd_chk("R2 alias write/read", 8'h0B, 8'hF8);
        rd_chk("R2 alt read", 8'h8B, 8'hF8);
        wr(8'h0C, 8'h00);
        rd_chk("R9 foreign write ignored", 8'h0B, 8'hF8);
        rd_chk("R2 foreign read zero", 8'h0C, 8'h00);
        wr(8'h0B, 8'h00);
        rd_chk("R2 clear via primary", 8'h8B, 8'h00);
    endtask

    task automatic t_timer;
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        rd_chk("R3/R9 timer flag with enables off", 8'h0B, 8'h04);
        chk("R7 no irq when gie off", {7'd0, irq}, 8'h00);
        idle(5);
        rd_chk("R3 timer flag sticky", 8'h0B, 8'h04);
        wr(8'h0B, 8'h00);
        rd_chk("R6 software clear", 8'h0B, 8'h00);
    endtask

    task automatic t_ext;
        @(negedge clk); ext_pin = 1'b1;
        @(posedge clk); @(posedge clk);
        #1 chk("R4 pin flag not early", bus_rdata & 8'h02, 8'h00);
        @(posedge clk);
        #1 chk("R4 pin rising edge", bus_rdata, 8'h02);
        wr(8'h0B, 8'h00);
        @(negedge clk); ext_pin = 1'b0;
        idle(5);
        rd_chk("R4 falling edge ignored", 8'h0B, 8'h00);
    endtask

    task automatic t_port;
        @(negedge clk); ioc_en = 6'b000101;
        idle(3);
        rd_chk("R5 enabling alone no change", 8'h0B, 8'h00);
        @(negedge clk); port_pins = 6'b000010;
        idle(5);
        rd_chk("R5 masked pin ignored", 8'h0B, 8'h00);
        @(negedge clk); port_pins = 6'b000110;
        idle(5);
        rd_chk("R5 enabled pin rise", 8'h0B, 8'h01);
        wr(8'h0B, 8'h00);
        @(negedge clk); port_pins = 6'b000010;
        idle(5);
        rd_chk("R5 enabled pin fall", 8'h0B, 8'h01);
        wr(8'h0B, 8'h00);
        @(negedge clk); port_pins = 6'b000000;
        idle(5);
        rd_chk("R5 masked pin fall ignored", 8'h0B, 8'h00);
    endtask

    task automatic t_irq;
        wr(8'h0B, 8'h90);
        chk("R7 enable without flag", {7'd0, irq}, 8'h00);
        wr(8'h0B, 8'h92);
        chk("R7 pin source raises irq", {7'd0, irq}, 8'h01);
        wr(8'h0B, 8'h12);
        chk("R7 gie off masks", {7'd0, irq}, 8'h00);
        wr(8'h0B, 8'hA4);
        chk("R7 timer source raises irq", {7'd0, irq}, 8'h01);
        wr(8'h0B, 8'h84);
        chk("R7 flag without enable", {7'd0, irq}, 8'h00);
        wr(8'h0B, 8'h89);
        chk("R7 port source raises irq", {7'd0, irq}, 8'h01);
        wr(8'h0B, 8'h00);
    endtask

    task automatic t_periph;
        wr(8'h0B, 8'hC0);
        @(negedge clk); periph_req = 1'b1;
        #1 chk("R8 group request passes", {7'd0, irq}, 8'h01);
        wr(8'h0B, 8'h80);
        chk("R8 group enable off", {7'd0, irq}, 8'h00);
        wr(8'h0B, 8'h40);
        chk("R8 gie off", {7'd0, irq}, 8'h00);
        @(negedge clk); periph_req = 1'b0;
        wr(8'h0B, 8'h00);
    endtask

    task automatic t_race;
        wr(8'h0B, 8'h04);
        @(negedge clk);
        bus_addr = 8'h8B; bus_wdata = 8'h00; bus_we = 1'b1; tmr_ovf = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tmr_ovf = 1'b0;
        rd_chk("R6 event beats clear", 8'h0B, 8'h04);
        wr(8'h0B, 8'h00);
    endtask

    initial begin
        fork
            begin
                idle(3);
                rst_n = 1'b1;
                idle(2);
                t_reset();
                t_address();
                t_timer();
                t_ext();
                t_port();
                t_irq();
                t_periph();
                t_race();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule